// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block models the output cells of a programmable sum-of-products device. Each lane receives a sum term from the logic array, its own output-enable term, and two configuration bits. The configuration picks between a clocked path through a D flip-flop and a direct combinational path, and between true and inverted output polarity. Every lane produces a pad drive value, a pad enable, and a feedback pair (true and complement) for the logic array.

All lanes share one clock, one asynchronous clear term and one synchronous set term, as the cells of such a device do. Clear and set act on the flip-flop state, before the polarity stage. For test, a preload strobe loads any chosen pattern into the flip-flops on a clock edge, so that illegal machine states can be forced and the next-state logic exercised from them. The tri-state pad is not modelled: the block exposes a drive value and an enable, and takes the pad-side level back in on a separate input.

Top module: `omc_macrocell`

## Requirements
- R1: Per lane, cfg_s1_i=0 selects registered mode and cfg_s1_i=1 selects combinational mode; cfg_s0_i=1 selects true (active-high) output and cfg_s0_i=0 selects inverted (active-low) output.
- R2: In registered mode pin_o equals the flip-flop state when cfg_s0_i=1 and its inverse when cfg_s0_i=0.
- R3: In registered mode fb_o equals the inverse of the flip-flop state and fb_n_o equals the state, whatever pad_i and the output enable are.
- R4: In combinational mode pin_o equals sum_i when cfg_s0_i=1 and its inverse when cfg_s0_i=0.
- R5: In combinational mode fb_o equals pin_o while the lane is enabled and pad_i while it is disabled; fb_n_o is always the inverse of fb_o.
- R6: pin_oe_o follows oe_term_i of the same lane in both modes.
- R7: While ar_i is high, every flip-flop reads 0 at once, with no clock edge needed.
- R8: With sp_i high at a rising edge, every flip-flop becomes 1.
- R9: Clear and set act on the flip-flop state regardless of polarity, so after a clear a registered lane drives pin_o=0 when active-high and pin_o=1 when active-low.
- R10: While rst_ni is low every flip-flop reads 0 (power-up clear).
- R11: With pl_en_i high at a rising edge, each flip-flop loads its bit of pl_val_i.
- R12: Priority at an edge is clear, then preload, then set, then capture of sum_i.
- R13: With none of clear, preload or set active, each flip-flop captures its lane's sum_i at every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Active-low power-up clear of all flip-flops |
| sum_i | input | LANES | Sum term per lane |
| oe_term_i | input | LANES | Output-enable term per lane |
| ar_i | input | 1 | Shared asynchronous clear term |
| sp_i | input | 1 | Shared synchronous set term |
| cfg_s0_i | input | LANES | Polarity bit per lane (1 = true) |
| cfg_s1_i | input | LANES | Mode bit per lane (1 = combinational) |
| pl_en_i | input | 1 | Preload strobe |
| pl_val_i | input | LANES | Preload pattern |
| pad_i | input | LANES | Pad-side level read back |
| pin_o | output | LANES | Pad drive value |
| pin_oe_o | output | LANES | Pad drive enable |
| fb_o | output | LANES | Feedback into the array, true |
| fb_n_o | output | LANES | Feedback into the array, complement |

## Verification
The bench builds the block with the default LANES=4, so one run holds lanes in all four mode and polarity codes at once. That exposes the shared clear, set and preload acting on lanes of both polarities in the same cycle, and registered lanes ignoring pad_i while combinational neighbours read it back. Random mixes of clear, set, preload and reset with per-lane configuration changes reach every priority combination.

// File: rtl/omc_pkg.sv
package omc_pkg;
  typedef struct packed {
    logic registered;
    logic act_high;
  } cell_cfg_t;

  function automatic cell_cfg_t decode_cfg(logic s0, logic s1);
    cell_cfg_t c;
    c.registered = ~s1;
    c.act_high   = s0;
    return c;
  endfunction
endpackage

// File: rtl/omc_cfg_dec.sv
module omc_cfg_dec
  import omc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]      s0_i,
  input  logic [LANES-1:0]      s1_i,
  output cell_cfg_t [LANES-1:0] cfg_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_dec
    assign cfg_o[l] = decode_cfg(s0_i[l], s1_i[l]);
  end
endmodule

// File: rtl/omc_state_reg.sv
module omc_state_reg #(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ar_i,
  input  logic             sp_i,
  input  logic             pl_en_i,
  input  logic [LANES-1:0] pl_val_i,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] q_o
);
  // clear > preload > set > capture
  always_ff @(posedge clk_i or negedge rst_ni or posedge ar_i) begin
    if (!rst_ni)      q_o <= '0;
    else if (ar_i)    q_o <= '0;
    else if (pl_en_i) q_o <= pl_val_i;
    else if (sp_i)    q_o <= '1;
    else              q_o <= d_i;
  end
endmodule

// File: rtl/omc_out_sel.sv
module omc_out_sel
  import omc_pkg::*;
(
  input  cell_cfg_t cfg_i,
  input  logic      q_i,
  input  logic      sum_i,
  input  logic      oe_i,
  input  logic      pad_i,
  output logic      pin_o,
  output logic      pin_oe_o,
  output logic      fb_o,
  output logic      fb_n_o
);
  logic src;

  always_comb begin
    src      = cfg_i.registered ? q_i : sum_i;
    pin_o    = cfg_i.act_high ? src : ~src;
    pin_oe_o = oe_i;
    // registered: from inverted state; combinational: pad side of buffer
    if (cfg_i.registered) fb_o = ~q_i;
    else                  fb_o = oe_i ? pin_o : pad_i;
    fb_n_o   = ~fb_o;
  end
endmodule

// File: rtl/omc_macrocell.sv
module omc_macrocell
  import omc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] sum_i,
  input  logic [LANES-1:0] oe_term_i,
  input  logic             ar_i,
  input  logic             sp_i,
  input  logic [LANES-1:0] cfg_s0_i,
  input  logic [LANES-1:0] cfg_s1_i,
  input  logic             pl_en_i,
  input  logic [LANES-1:0] pl_val_i,
  input  logic [LANES-1:0] pad_i,
  output logic [LANES-1:0] pin_o,
  output logic [LANES-1:0] pin_oe_o,
  output logic [LANES-1:0] fb_o,
  output logic [LANES-1:0] fb_n_o
);
  cell_cfg_t [LANES-1:0] cfg;
  logic      [LANES-1:0] q;

  omc_cfg_dec #(.LANES(LANES)) i_cfg_dec (
    .s0_i  (cfg_s0_i),
    .s1_i  (cfg_s1_i),
    .cfg_o (cfg)
  );

  omc_state_reg #(.LANES(LANES)) i_state_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ar_i     (ar_i),
    .sp_i     (sp_i),
    .pl_en_i  (pl_en_i),
    .pl_val_i (pl_val_i),
    .d_i      (sum_i),
    .q_o      (q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    omc_out_sel i_out_sel (
      .cfg_i    (cfg[l]),
      .q_i      (q[l]),
      .sum_i    (sum_i[l]),
      .oe_i     (oe_term_i[l]),
      .pad_i    (pad_i[l]),
      .pin_o    (pin_o[l]),
      .pin_oe_o (pin_oe_o[l]),
      .fb_o     (fb_o[l]),
      .fb_n_o   (fb_n_o[l])
    );
  end
endmodule

// File: rtl/omc_macrocell_chk.sv
module omc_macrocell_chk #(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LANES-1:0] sum_i,
  input logic [LANES-1:0] oe_term_i,
  input logic             ar_i,
  input logic             sp_i,
  input logic [LANES-1:0] cfg_s0_i,
  input logic [LANES-1:0] cfg_s1_i,
  input logic             pl_en_i,
  input logic [LANES-1:0] pl_val_i,
  input logic [LANES-1:0] pad_i,
  input logic [LANES-1:0] pin_o,
  input logic [LANES-1:0] fb_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // R7
    ar_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ar_i && !cfg_s1_i[l]) |-> fb_o[l]);
    // R8
    sp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(sp_i && !ar_i && !pl_en_i) && !ar_i && !cfg_s1_i[l])
      |-> !fb_o[l]);
    // R11 R12
    preload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(pl_en_i && !ar_i) && !ar_i && !cfg_s1_i[l])
      |-> (fb_o[l] == !$past(pl_val_i[l])));
    // R13
    capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(!pl_en_i && !sp_i && !ar_i) && !ar_i && !cfg_s1_i[l])
      |-> (fb_o[l] == !$past(sum_i[l])));
    // R2
    reg_pin_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_s1_i[l] |-> (pin_o[l] == (fb_o[l] ^ cfg_s0_i[l])));
    // R5
    comb_pad_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_s1_i[l] && !oe_term_i[l]) |-> (fb_o[l] == pad_i[l]));
  end
endmodule

bind omc_macrocell omc_macrocell_chk #(.LANES(LANES)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sum_i     (sum_i),
  .oe_term_i (oe_term_i),
  .ar_i      (ar_i),
  .sp_i      (sp_i),
  .cfg_s0_i  (cfg_s0_i),
  .cfg_s1_i  (cfg_s1_i),
  .pl_en_i   (pl_en_i),
  .pl_val_i  (pl_val_i),
  .pad_i     (pad_i),
  .pin_o     (pin_o),
  .fb_o      (fb_o)
);

// File: tb/test_omc_macrocell.sv
`timescale 1ns/1ps
module test_omc_macrocell;
  localparam int LANES = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [LANES-1:0] sum_i = '0, oe_term_i = '0, cfg_s0_i = '0, cfg_s1_i = '0;
  logic [LANES-1:0] pl_val_i = '0, pad_i = '0;
  logic             ar_i = 1'b0, sp_i = 1'b0, pl_en_i = 1'b0;
  logic [LANES-1:0] pin_o, pin_oe_o, fb_o, fb_n_o;

  int    n_vec = 0;
  int    n_bad = 0;
  string tag = "R10";
  logic [LANES-1:0] q_m = '0;

  always #5 clk_i = ~clk_i;

  omc_macrocell #(.LANES(LANES)) i_omc_macrocell (
    .clk_i, .rst_ni, .sum_i, .oe_term_i, .ar_i, .sp_i, .cfg_s0_i, .cfg_s1_i,
    .pl_en_i, .pl_val_i, .pad_i, .pin_o, .pin_oe_o, .fb_o, .fb_n_o
  );

  // reference state: clear (R7 R10) > preload (R11) > set (R8) > capture (R13), R12
  always @(posedge clk_i) begin
    if (!rst_ni || ar_i) q_m <= '0;
    else if (pl_en_i)    q_m <= pl_val_i;
    else if (sp_i)       q_m <= '1;
    else                 q_m <= sum_i;
  end

  task automatic check_all();
    for (int l = 0; l < LANES; l++) begin
      logic q, pin, fb;
      logic [3:0] exp_v, got_v;
      q = (!rst_ni || ar_i) ? 1'b0 : q_m[l];
      if (!cfg_s1_i[l]) pin = cfg_s0_i[l] ? q : !q;
      else              pin = cfg_s0_i[l] ? sum_i[l] : !sum_i[l];
      if (!cfg_s1_i[l]) fb = !q;
      else              fb = oe_term_i[l] ? pin : pad_i[l];
      exp_v = {pin, oe_term_i[l], fb, !fb};
      got_v = {pin_o[l], pin_oe_o[l], fb_o[l], fb_n_o[l]};
      n_vec++;
      if (got_v !== exp_v) begin
        n_bad++;
        $display("FAIL %s lane %0d mode=%b pol=%b got %b exp %b",
                 tag, l, cfg_s1_i[l], cfg_s0_i[l], got_v, exp_v);
      end
    end
  endtask

  // mode_sel: 0 all registered, 1 all combinational, 2 random per lane
  task automatic run(string t, int n, int mode_sel, int p_ar, int p_sp, int p_pl, int p_rst);
    tag = t;
    for (int c = 0; c < n; c++) begin
      @(negedge clk_i);
      sum_i     = LANES'($urandom);
      oe_term_i = LANES'($urandom);
      pad_i     = LANES'($urandom);
      pl_val_i  = LANES'($urandom);
      cfg_s0_i  = LANES'($urandom);
      case (mode_sel)
        0:       cfg_s1_i = '0;
        1:       cfg_s1_i = '1;
        default: cfg_s1_i = LANES'($urandom);
      endcase
      ar_i    = ($urandom % 100) < p_ar;
      sp_i    = ($urandom % 100) < p_sp;
      pl_en_i = ($urandom % 100) < p_pl;
      rst_ni  = !(($urandom % 100) < p_rst);
      #1 check_all();
    end
  endtask

  initial begin
    run("R10", 5, 2, 0, 0, 0, 100);
    run("R2 R3 R13", 60, 0, 0, 0, 0, 0);
    run("R4 R5 R6", 60, 1, 0, 0, 0, 0);
    run("R1", 60, 2, 0, 0, 0, 0);
    run("R7 R9", 80, 0, 30, 0, 0, 0);
    run("R8 R9", 80, 0, 0, 30, 0, 0);
    run("R11", 80, 0, 0, 0, 40, 0);
    run("R12", 300, 2, 30, 40, 40, 0);
    run("R10", 150, 2, 5, 10, 10, 15);
    run("R1 R12 R13", 2000, 2, 5, 8, 8, 1);
    @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule